// File: doc/BRIEF.md
# Sigma-Delta 512x Decimation Chain

This block turns the single-bit stream from a sigma-delta modulator into wide PCM audio samples at 1/512 of the input rate. A bit arrives on every clock. A fourth-order cascaded integrator-comb (CIC) section reduces the rate by 64. Three half-band FIR decimators follow it, and each of them halves the rate again. At a 98.304 MHz bit clock the output rate is 192 kHz.

Every stage runs on the one clock and is gated by single-cycle strobes; the chain derives no clocks. The integrators sit behind registers, so each integrator adds the value that the stage before it held one clock earlier. The half-band coefficients are applied with shifts and adds in canonic signed digit form, and the chain contains no general multiplier. The last stage's result is sign-extended to 32 bits and moved up to the top of that word.

Top module: `sd_decim512`

## Requirements
- R1: A bit value of 1 counts as +1 and a bit value of 0 counts as -1. A steady stream of ones settles `pcm_out` to +134217728 (2^27). A steady stream of zeros settles it to -134217728.
- R2: The CIC has 4 integrators and 4 combs, and it decimates by 64. Integrator k adds the previous-clock value of integrator k-1; integrator 0 adds the current bit. The combs run once per 64 clocks, on the 64th, 128th, ... bit after reset. Each comb uses the value that the stage before it produced for the same sample.
- R3: The CIC state is 26 bits of two's complement and wraps on overflow. The CIC output is still exact for bit streams of any length.
- R4: Each half-band stage computes only on its even-numbered inputs (2nd, 4th, ...). It emits exactly one output per two inputs, one clock after the input that triggers it.
- R5: Stages 1 and 2 use the taps {-1,0,9,16,9,0,-1}/32. Stage 3 uses {3,0,-25,0,150,256,150,0,-25,0,3}/512. The division is an arithmetic right shift, which rounds toward minus infinity.
- R6: A half-band stage produces nothing until its delay line is full. Its first output falls on the first even input index that is at least its tap count, which is input 8 for 7 taps and input 12 for 11 taps.
- R7: Synchronous reset clears all state and forces `pcm_valid` and `pcm_out` to 0. Reset wins over any strobe in the same clock. After release, `pcm_valid` stays low for the first 4224 clocks.
- R8: After the first output, `pcm_valid` is a one-clock pulse that repeats exactly every 512 clocks.
- R9: `pcm_out` equals the 29-bit result of stage 3, sign-extended and shifted left by 3. Its three low bits are always 0.
- R10: For any bit pattern, the sequence of values on `pcm_out` equals the chain formed by R1 to R9, applied to the bits fed in since the last reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one modulator bit per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Modulator output bit (1 means +1, 0 means -1) |
| pcm_out | output | 32 | Signed PCM sample, valid while `pcm_valid` is high |
| pcm_valid | output | 1 | One-clock strobe that marks a new sample |

## Verification
Two events can fall in the same clock: a synchronous reset and the edge on which the chain would raise `pcm_valid`. The bench measures when the first output appears. It then asserts reset on exactly the clock 512 cycles later, when the second output is due. It judges the result by three observations: no strobe appears on that clock, the sample taken before the reset matches the reference chain, and the outputs after release match a fresh reference chain that starts from the bits fed after the reset.

// File: rtl/sdd_pkg.sv
package sdd_pkg;
    localparam int COEF_W = 16;

    // 7-tap half-band, gain 32
    localparam int HB_SHORT_TAPS  = 7;
    localparam int HB_SHORT_SHIFT = 5;
    localparam logic [HB_SHORT_TAPS*COEF_W-1:0] HB_SHORT_COEFS = {
        16'hFFFF, 16'd0, 16'd9, 16'd16, 16'd9, 16'd0, 16'hFFFF
    };

    // 11-tap half-band, gain 512
    localparam int HB_LONG_TAPS  = 11;
    localparam int HB_LONG_SHIFT = 9;
    localparam logic [HB_LONG_TAPS*COEF_W-1:0] HB_LONG_COEFS = {
        16'd3, 16'd0, 16'hFFE7, 16'd0, 16'd150, 16'd256,
        16'd150, 16'd0, 16'hFFE7, 16'd0, 16'd3
    };
endpackage

// File: rtl/sdd_cic.sv
module sdd_cic #(
    parameter int ORDER = 4,
    parameter int RATE  = 64,
    localparam int LOG_R = $clog2(RATE),
    localparam int W     = 2 + ORDER * LOG_R
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bit_in,
    output logic [W-1:0] smp_out,
    output logic         smp_valid
);
    typedef struct packed {
        logic [ORDER-1:0][W-1:0] integ;
        logic [LOG_R-1:0]        cnt;
        logic [W-1:0]            samp;
        logic [ORDER-1:0][W-1:0] comb;
        logic [ORDER-1:0][W-1:0] dly;
        logic [ORDER:0]          stb;
    } cic_state_t;

    cic_state_t st_q, st_d;

    always_comb begin
        logic [W-1:0] src;
        st_d = st_q;
        // integrators: one register per stage, stage k sees stage k-1 one clock late
        st_d.integ[0] = st_q.integ[0] + (bit_in ? W'(1) : {W{1'b1}});
        for (int k = 1; k < ORDER; k++) begin
            st_d.integ[k] = st_q.integ[k] + st_q.integ[k-1];
        end
        st_d.cnt    = (st_q.cnt == LOG_R'(RATE - 1)) ? '0 : st_q.cnt + 1'b1;
        st_d.stb[0] = (st_q.cnt == LOG_R'(RATE - 1));
        if (st_d.stb[0]) begin
            st_d.samp = st_d.integ[ORDER-1];
        end
        // combs: a wave of strobes, one register per comb stage
        for (int k = 0; k < ORDER; k++) begin
            st_d.stb[k+1] = st_q.stb[k];
            src = (k == 0) ? st_q.samp : st_q.comb[(k == 0) ? 0 : k-1];
            if (st_q.stb[k]) begin
                st_d.comb[k] = src - st_q.dly[k];
                st_d.dly[k]  = src;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign smp_out   = st_q.comb[ORDER-1];
    assign smp_valid = st_q.stb[ORDER];

    // R2: decimated strobe never lasts two clocks
    p_cic_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> !smp_valid);
    // R2: a CIC sample follows the decimation strobe by the comb depth
    p_cic_stb_r2: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> $past(st_q.stb[ORDER-1]));
endmodule

// File: rtl/sdd_halfband.sv
module sdd_halfband #(
    parameter int WI    = 26,
    parameter int TAPS  = 7,
    parameter int SHIFT = 5,
    parameter logic [TAPS*sdd_pkg::COEF_W-1:0] COEFS = sdd_pkg::HB_SHORT_COEFS,
    localparam int CW  = sdd_pkg::COEF_W,
    localparam int WO  = WI + 1,
    localparam int DL  = TAPS - 1,
    localparam int AW  = WI + CW + $clog2(TAPS),
    localparam int FW  = $clog2(TAPS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [WI-1:0] in_dat,
    input  logic          in_valid,
    output logic [WO-1:0] out_dat,
    output logic          out_valid
);
    typedef struct packed {
        logic [DL-1:0][WI-1:0] dl;
        logic                  phase;
        logic [FW-1:0]         fill;
        logic [WO-1:0]         out;
        logic                  ov;
    } hb_state_t;

    hb_state_t st_q, st_d;

    // constant multiply as signed-digit shift/add terms
    function automatic logic signed [AW-1:0] csd_mul(input logic signed [AW-1:0] x,
                                                     input int coef);
        logic signed [AW-1:0] acc;
        int c;
        acc = '0;
        c   = coef;
        for (int i = 0; i < CW + 2; i++) begin
            if (c[0]) begin
                if (c[1]) begin
                    acc = acc - (x <<< i);
                    c   = c + 1;
                end else begin
                    acc = acc + (x <<< i);
                    c   = c - 1;
                end
            end
            c = c >>> 1;
        end
        return acc;
    endfunction

    always_comb begin
        logic signed [AW-1:0] acc;
        logic signed [AW-1:0] scaled;
        logic [WI-1:0]        tap;
        logic                 fire;
        st_d    = st_q;
        st_d.ov = 1'b0;
        acc     = '0;
        for (int k = 0; k < TAPS; k++) begin
            tap = (k == 0) ? in_dat : st_q.dl[(k == 0) ? 0 : k-1];
            acc = acc + csd_mul(AW'($signed(tap)),
                                int'($signed(COEFS[k*CW +: CW])));
        end
        scaled = acc >>> SHIFT;
        fire   = in_valid && st_q.phase && (st_q.fill >= FW'(TAPS - 1));
        if (in_valid) begin
            st_d.dl[0] = in_dat;
            for (int k = 1; k < DL; k++) begin
                st_d.dl[k] = st_q.dl[k-1];
            end
            st_d.phase = ~st_q.phase;
            if (st_q.fill < FW'(TAPS)) st_d.fill = st_q.fill + 1'b1;
        end
        if (fire) begin
            st_d.out = scaled[WO-1:0];
            st_d.ov  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_dat   = st_q.out;
    assign out_valid = st_q.ov;

    // R4: every output is caused by an input one clock earlier
    p_hb_after_input_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));
    // R4: outputs come at most once per two inputs, never back to back
    p_hb_single_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);
endmodule

// File: rtl/sd_decim512.sv
module sd_decim512 #(
    parameter int CIC_ORDER = 4,
    parameter int CIC_RATE  = 64,
    parameter int OUT_W     = 32,
    parameter int HB_A_TAPS  = sdd_pkg::HB_SHORT_TAPS,
    parameter int HB_A_SHIFT = sdd_pkg::HB_SHORT_SHIFT,
    parameter logic [HB_A_TAPS*sdd_pkg::COEF_W-1:0] HB_A_COEFS = sdd_pkg::HB_SHORT_COEFS,
    parameter int HB_B_TAPS  = sdd_pkg::HB_LONG_TAPS,
    parameter int HB_B_SHIFT = sdd_pkg::HB_LONG_SHIFT,
    parameter logic [HB_B_TAPS*sdd_pkg::COEF_W-1:0] HB_B_COEFS = sdd_pkg::HB_LONG_COEFS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_in,
    output logic [OUT_W-1:0] pcm_out,
    output logic             pcm_valid
);
    localparam int NUM_HB = 3;
    localparam int W0     = 2 + CIC_ORDER * $clog2(CIC_RATE);
    localparam int W_MAX  = W0 + NUM_HB;
    localparam int OSH    = OUT_W - W_MAX;
    localparam int DEC    = CIC_RATE * (1 << NUM_HB);
    localparam int GW     = $clog2(DEC) + 1;

    logic [W_MAX-1:0] hb_dat [NUM_HB+1];
    logic             hb_vld [NUM_HB+1];
    logic [W0-1:0]    cic_dat;

    sdd_cic #(.ORDER(CIC_ORDER), .RATE(CIC_RATE)) u_cic (
        .clk(clk), .rst(rst), .bit_in(bit_in),
        .smp_out(cic_dat), .smp_valid(hb_vld[0])
    );
    assign hb_dat[0] = W_MAX'($signed(cic_dat));

    for (genvar s = 0; s < NUM_HB; s++) begin : g_hb
        logic [W0+s:0] y;
        if (s < NUM_HB - 1) begin : g_short
            sdd_halfband #(.WI(W0+s), .TAPS(HB_A_TAPS), .SHIFT(HB_A_SHIFT),
                           .COEFS(HB_A_COEFS)) u_hb (
                .clk(clk), .rst(rst),
                .in_dat(hb_dat[s][W0+s-1:0]), .in_valid(hb_vld[s]),
                .out_dat(y), .out_valid(hb_vld[s+1])
            );
        end else begin : g_long
            sdd_halfband #(.WI(W0+s), .TAPS(HB_B_TAPS), .SHIFT(HB_B_SHIFT),
                           .COEFS(HB_B_COEFS)) u_hb (
                .clk(clk), .rst(rst),
                .in_dat(hb_dat[s][W0+s-1:0]), .in_valid(hb_vld[s]),
                .out_dat(y), .out_valid(hb_vld[s+1])
            );
        end
        assign hb_dat[s+1] = W_MAX'($signed(y));
    end

    assign pcm_out   = OUT_W'($signed(hb_dat[NUM_HB])) <<< OSH;
    assign pcm_valid = hb_vld[NUM_HB];

    // spacing checker state
    logic [GW-1:0] gap_q;
    logic          seen_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (pcm_valid) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    // R7: reset forces the strobe low on the following clock
    p_reset_quiet_r7: assert property (@(posedge clk)
        rst |=> !pcm_valid);
    // R8: consecutive samples are exactly DEC clocks apart
    p_spacing_r8: assert property (@(posedge clk) disable iff (rst)
        (pcm_valid && seen_q) |-> (gap_q == GW'(DEC - 1)));
    // R1: full-scale stream cannot push the output beyond twice full scale
    p_out_bound_r1: assert property (@(posedge clk) disable iff (rst)
        pcm_valid |-> ($signed(pcm_out) <= $signed(OUT_W'(1) <<< (OUT_W - 4))
                    && $signed(pcm_out) >= -$signed(OUT_W'(1) <<< (OUT_W - 4))));
endmodule

// File: tb/sd_decim512_test.sv
module sd_decim512_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_in = 1'b0;
    logic [31:0] pcm_out;
    logic        pcm_valid;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;
    longint got[$];
    int got_cyc[$];
    int first_cyc = 4230;

    always #2 clk = ~clk;

    sd_decim512 uut (.clk(clk), .rst(rst), .bit_in(bit_in),
                     .pcm_out(pcm_out), .pcm_valid(pcm_valid));

    always begin
        @(posedge clk);
        #1;
        if (pcm_valid) begin
            got.push_back(longint'($signed(pcm_out)));
            got_cyc.push_back(cyc);
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference chain from the requirements
    task automatic hb_model(ref longint xin[$], input int c[], input int sh, ref longint y[$]);
        y.delete();
        for (int j = 1; j <= xin.size(); j++) begin
            if (j % 2 == 0 && j >= c.size()) begin
                longint acc = 0;
                for (int k = 0; k < c.size(); k++) acc += c[k] * xin[j-1-k];
                y.push_back(acc >>> sh);
            end
        end
    endtask

    task automatic chain_model(input bit b[], ref longint out[$]);
        longint ig[4] = '{default: 0};
        longint cd[4] = '{default: 0};
        longint s0[$], s1[$], s2[$], s3[$];
        int cnt = 0;
        int ca[] = '{-1, 0, 9, 16, 9, 0, -1};
        int cb[] = '{3, 0, -25, 0, 150, 256, 150, 0, -25, 0, 3};
        foreach (b[i]) begin
            for (int k = 3; k >= 1; k--) ig[k] += ig[k-1];
            ig[0] += b[i] ? 1 : -1;
            cnt++;
            if (cnt == 64) begin
                longint s = ig[3];
                cnt = 0;
                for (int k = 0; k < 4; k++) begin
                    longint t = s - cd[k];
                    cd[k] = s;
                    s = t;
                end
                s0.push_back(s);
            end
        end
        hb_model(s0, ca, 5, s1);
        hb_model(s1, ca, 5, s2);
        hb_model(s2, cb, 9, s3);
        out.delete();
        foreach (s3[i]) out.push_back(s3[i] <<< 3);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        got.delete();
        got_cyc.delete();
    endtask

    task automatic drive(input bit b[], input int rst_at, input int rst_len);
        for (int i = 0; i < b.size(); i++) begin
            @(negedge clk);
            rst = (i >= rst_at && i < rst_at + rst_len);
            bit_in = b[i];
            cyc = i;
        end
        @(negedge clk);
        rst = 1'b1;
    endtask

    task automatic make_bits(input int kind, input int n, ref bit b[]);
        b = new[n];
        for (int i = 0; i < n; i++) begin
            case (kind)
                0: b[i] = 1'b1;
                1: b[i] = 1'b0;
                2: b[i] = i[0];
                3: b[i] = ($urandom_range(0, 999) < 500);
                4: b[i] = ($urandom_range(0, 999) < 830);
                default: b[i] = i[8];
            endcase
        end
    endtask

    task automatic run_seq(input int kind, input string name);
        bit b[];
        longint exp[$];
        make_bits(kind, 12288, b);
        chain_model(b, exp);
        do_reset();
        drive(b, 1 << 30, 0);
        // R4 R6: one sample per 512 bits once the delay lines are full
        chk(got.size() == exp.size(), {name, " R4 R6 sample count"}, got.size(), exp.size());
        for (int k = 0; k < got.size() && k < exp.size(); k++)
            chk(got[k] == exp[k], {name, " R10 R5 R3 sample value"}, got[k], exp[k]);
        for (int k = 1; k < got_cyc.size(); k++)
            chk(got_cyc[k] - got_cyc[k-1] == 512, {name, " R8 spacing"},
                got_cyc[k] - got_cyc[k-1], 512);
        foreach (got[k])
            chk((got[k] & 7) == 0, {name, " R9 low bits"}, got[k] & 7, 0);
        if (got_cyc.size() > 0) begin
            chk(got_cyc[0] >= 4224 && got_cyc[0] < 4240, {name, " R7 R6 first strobe"},
                got_cyc[0], 4224);
            first_cyc = got_cyc[0];
        end
        if (kind == 0 && got.size() > 0)
            chk(got[got.size()-1] == 134217728, "R1 ones DC", got[got.size()-1], 134217728);
        if (kind == 1 && got.size() > 0)
            chk(got[got.size()-1] == -134217728, "R1 zeros DC", got[got.size()-1], -134217728);
    endtask

    task automatic run_collision();
        bit b[], tail[];
        longint pre[$], post[$], after[$];
        int ra = first_cyc + 512;
        int n = ra + 2 + 5000;
        bit hit = 1'b0;
        make_bits(3, n, b);
        tail = new[n - ra - 2];
        foreach (tail[i]) tail[i] = b[ra + 2 + i];
        chain_model(b, pre);
        chain_model(tail, post);
        do_reset();
        drive(b, ra, 2);
        foreach (got_cyc[k]) begin
            if (got_cyc[k] == ra) hit = 1'b1;
            if (got_cyc[k] > ra + 1) after.push_back(got[k]);
        end
        // R7: reset wins over the strobe due in the same clock
        chk(!hit, "R7 collision strobe suppressed", hit, 0);
        chk(got.size() > 0 && pre.size() > 0 && got[0] == pre[0], "R10 pre-reset sample",
            got.size() > 0 ? got[0] : 0, pre.size() > 0 ? pre[0] : 0);
        chk(after.size() == post.size(), "R7 post-reset count", after.size(), post.size());
        for (int k = 0; k < after.size() && k < post.size(); k++)
            chk(after[k] == post[k], "R7 R10 post-reset value", after[k], post[k]);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R7: reset state at the ports
        chk(pcm_valid == 1'b0, "R7 reset valid", pcm_valid, 0);
        chk(pcm_out == 32'd0, "R7 reset data", pcm_out, 0);
        run_seq(0, "ones");
        run_seq(1, "zeros");
        run_seq(2, "alternating");
        run_seq(3, "random50");
        run_seq(4, "random83");
        run_seq(5, "square");
        run_collision();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule